// File: doc/BRIEF.md
# Vector Swizzle Move Sequencer

This block turns one vectorised swizzle move into an ordered stream of element moves. After a start pulse it latches a vector length, a source subvector length of 1 to 4, a 12-bit swizzle immediate and a set of mode flags. It then issues one move per cycle. Each move carries either a source element index with the lane it came from, or a constant, together with the destination element index that receives it. The register file that performs the moves sits outside the block.

Two index walkers, one for sources and one for destinations, step in lock step. The destination subvector length comes from an end marker inside the immediate, so it need not match the source subvector length. Each walker can run either subvector-major or vector-major. In vertical-first mode the stream is cut into groups, and the block waits for a step request between groups. With saturation on, a constant-one selector produces the largest value for the chosen element width.

Top module: `swz_seq`

## Requirements
- R1: The selector for subvector position k (k = 0..3) is `swz_imm[3k+2:3k]`. Code 000 means skip, 001 is the end marker, 010 is constant zero, 011 is constant one, and 1NN copies source lane NN. `mv_const` is 1 exactly for the constant codes.
- R2: The destination length is one plus the position of the lowest 001 selector, or 4 if there is none. The destination walker visits every position below that length, including the marker position itself, and skips 000 positions. With unpack off, the index is i*dst_len+j.
- R3: The source walker visits position j if j < source length, j lies below the first marker, and the selector is not 000. With pack off, a copy gives `mv_src_idx` = i*src_len+NN and `mv_lane` = NN.
- R4: The two walkers advance together. The n-th move pairs the n-th source item with the n-th destination index. The number of moves is the smaller of the two walkers' totals.
- R5: With pack on, the source walker runs over subvector position in the outer loop and over i in the inner loop, and a copy gives NN*VL+i.
- R6: With unpack on, the destination walker runs in the same outer order, with index j*VL+i. Pack and unpack may both be on.
- R7: Constant zero always gives 0. Constant one gives 1 when saturation is off. With saturation on and element width w = 8<<`ew_sel`, it gives 2^(w-1)-1 when signed and 2^w-1 when unsigned.
- R8: A start pulse latches the configuration and clears both walkers, even when a sequence is already running. The cycle after start carries no move, and the first move appears two cycles after start.
- R9: `seq_done` is high for exactly one cycle, in the cycle after the last move. When VL is 0 or a walker has no items, there is no move and `seq_done` comes two cycles after start.
- R10: In vertical-first mode the group size is 1 with pack and unpack both on, dst_len with only pack on, and src_len otherwise. After a full group the block waits, issuing no moves, until `step_req`. `grp_done` pulses in the cycle after each group's last move. A short final group also pulses `grp_done`, in the same cycle as `seq_done`.
- R11: Outside vertical-first mode, moves come out on consecutive cycles, `step_req` has no effect and `grp_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch configuration and begin a sequence |
| step_req | input | 1 | Release the next vertical-first group |
| vl_in | input | VL_W | Vector length |
| subvl_m1 | input | 2 | Source subvector length minus one |
| swz_imm | input | 12 | Four 3-bit selectors |
| pack_en | input | 1 | Source walker in outer order |
| unpack_en | input | 1 | Destination walker in outer order |
| vfirst | input | 1 | Vertical-first grouping |
| sat_en | input | 1 | Saturated constant one |
| sat_signed | input | 1 | Signed saturation limit |
| ew_sel | input | 2 | Element width 8<<ew_sel bits |
| mv_valid | output | 1 | A move is issued this cycle |
| mv_const | output | 1 | Move writes a constant |
| mv_src_idx | output | VL_W+2 | Source element index |
| mv_lane | output | 2 | Selected source lane |
| mv_const_val | output | 64 | Constant value |
| mv_dst_idx | output | VL_W+2 | Destination element index |
| grp_done | output | 1 | Vertical-first group finished |
| seq_done | output | 1 | Sequence finished |

## Verification
The end of the last vertical-first group and the end of the whole sequence land in the same cycle. `grp_done` and `seq_done` must then rise together, even when the final group is shorter than the group size. Random vector lengths, subvector lengths and selector patterns, with vertical-first, pack and unpack chosen at random, produce both short and full final groups. For every `grp_done` the bench checks that the running move count equals the previous group boundary plus the group size, capped at the expected total. On `seq_done` it checks that `grp_done` is present whenever at least one move was issued, and that the number of groups is the rounded-up quotient.

// File: rtl/swz_pkg.sv
package swz_pkg;

    localparam int DW = 64;

    localparam logic [2:0] SEL_SKIP = 3'b000;
    localparam logic [2:0] SEL_END  = 3'b001;
    localparam logic [2:0] SEL_ONE  = 3'b011;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_HOLD} seq_st_t;

    typedef struct packed {
        logic [11:0] swz;
        logic [1:0]  sub_m1;
        logic        pack;
        logic        unpack;
        logic        vf;
        logic        sat;
        logic        sgn;
        logic [1:0]  ew;
    } swz_cfg_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] pos;
    } scan_t;

    function automatic logic [2:0] sel_of(input logic [11:0] imm, input logic [1:0] k);
        return imm[3*k +: 3];
    endfunction

    // lowest position holding the end marker
    function automatic scan_t marker_scan(input logic [11:0] imm);
        scan_t r;
        r = '0;
        for (int k = 3; k >= 0; k--)
            if (sel_of(imm, 2'(k)) == SEL_END) begin
                r.hit = 1'b1;
                r.pos = 2'(k);
            end
        return r;
    endfunction

    function automatic logic [2:0] dst_len(input logic [11:0] imm);
        scan_t m;
        m = marker_scan(imm);
        return m.hit ? ({1'b0, m.pos} + 3'd1) : 3'd4;
    endfunction

    function automatic logic [3:0] src_mask(input logic [11:0] imm, input logic [1:0] sub_m1);
        scan_t m;
        logic [3:0] r;
        m = marker_scan(imm);
        for (int k = 0; k < 4; k++)
            r[k] = (2'(k) <= sub_m1) && (!m.hit || (2'(k) < m.pos))
                   && (sel_of(imm, 2'(k)) != SEL_SKIP);
        return r;
    endfunction

    function automatic logic [3:0] dst_mask(input logic [11:0] imm);
        logic [2:0] len;
        logic [3:0] r;
        len = dst_len(imm);
        for (int k = 0; k < 4; k++)
            r[k] = (3'(k) < len) && (sel_of(imm, 2'(k)) != SEL_SKIP);
        return r;
    endfunction

    // lowest set bit of m at or above position 'from'
    function automatic scan_t lowest_from(input logic [3:0] m, input logic [2:0] from);
        scan_t r;
        r = '0;
        for (int k = 3; k >= 0; k--)
            if (m[k] && (3'(k) >= from)) begin
                r.hit = 1'b1;
                r.pos = 2'(k);
            end
        return r;
    endfunction

    function automatic logic [DW-1:0] const_val(input logic [2:0] sel, input logic sat,
                                                input logic sgn, input logic [1:0] ew);
        logic [6:0] width;
        logic [6:0] sh;
        if (sel != SEL_ONE) return '0;
        if (!sat) return DW'(1);
        width = 7'd8 << ew;
        sh    = 7'd64 - width + {6'd0, sgn};
        return {DW{1'b1}} >> sh;
    endfunction

endpackage

// File: rtl/swz_walker.sv
module swz_walker
    import swz_pkg::*;
#(
    parameter int VL_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            init,
    input  logic            adv,
    input  logic [3:0]      mask,
    input  logic            outer,
    input  logic [VL_W-1:0] vl,
    output logic [VL_W-1:0] i_pos,
    output logic [1:0]      j_pos,
    output logic            ex,
    output logic            last
);

    logic [VL_W-1:0] i_q, i_n;
    logic [1:0]      j_q, j_n;
    logic            ex_q, ex_n, i_more;
    scan_t           lo, hi;

    always_comb begin
        i_more = ({1'b0, i_q} + 1'b1) < {1'b0, vl};
        lo     = lowest_from(mask, 3'd0);
        hi     = lowest_from(mask, {1'b0, j_q} + 3'd1);
        i_n    = i_q;
        j_n    = j_q;
        ex_n   = 1'b0;
        if (outer) begin
            if (i_more) begin
                i_n = i_q + 1'b1;
            end else if (hi.hit) begin
                i_n = '0;
                j_n = hi.pos;
            end else begin
                ex_n = 1'b1;
            end
        end else begin
            if (hi.hit) begin
                j_n = hi.pos;
            end else if (i_more) begin
                i_n = i_q + 1'b1;
                j_n = lo.pos;
            end else begin
                ex_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            i_q  <= '0;
            j_q  <= '0;
            ex_q <= 1'b1;
        end else if (init) begin
            i_q  <= '0;
            j_q  <= lo.pos;
            ex_q <= (vl == '0) || !lo.hit;
        end else if (adv && !ex_q) begin
            i_q  <= i_n;
            j_q  <= j_n;
            ex_q <= ex_n;
        end
    end

    assign i_pos = i_q;
    assign j_pos = j_q;
    assign ex    = ex_q;
    assign last  = !ex_q && ex_n;

endmodule

// File: rtl/swz_seq.sv
module swz_seq
    import swz_pkg::*;
#(
    parameter int VL_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step_req,
    input  logic [VL_W-1:0]   vl_in,
    input  logic [1:0]        subvl_m1,
    input  logic [11:0]       swz_imm,
    input  logic              pack_en,
    input  logic              unpack_en,
    input  logic              vfirst,
    input  logic              sat_en,
    input  logic              sat_signed,
    input  logic [1:0]        ew_sel,
    output logic              mv_valid,
    output logic              mv_const,
    output logic [VL_W+1:0]   mv_src_idx,
    output logic [1:0]        mv_lane,
    output logic [DW-1:0]     mv_const_val,
    output logic [VL_W+1:0]   mv_dst_idx,
    output logic              grp_done,
    output logic              seq_done
);

    localparam int IDX_W = VL_W + 2;
    localparam int NWALK = 2;   // 0: source, 1: destination

    seq_st_t         st_q;
    swz_cfg_t        cfg_q;
    logic [VL_W-1:0] vl_q;
    logic [2:0]      cnt_q;
    logic            grp_q;

    logic [2:0]      d_len, s_len, g_size, s_sel;
    logic            fire, last_mv, cnt_hit, any_ex;
    logic            cfg_vf, cfg_sat;

    logic [NWALK-1:0][3:0]      w_mask;
    logic [NWALK-1:0]           w_outer, w_ex, w_last;
    logic [NWALK-1:0][VL_W-1:0] w_i;
    logic [NWALK-1:0][1:0]      w_j;

    always_comb begin
        w_mask[0]  = src_mask(cfg_q.swz, cfg_q.sub_m1);
        w_mask[1]  = dst_mask(cfg_q.swz);
        w_outer[0] = cfg_q.pack;
        w_outer[1] = cfg_q.unpack;
        d_len      = dst_len(cfg_q.swz);
        s_len      = {1'b0, cfg_q.sub_m1} + 3'd1;
        if (cfg_q.pack && cfg_q.unpack) g_size = 3'd1;
        else if (cfg_q.pack)            g_size = d_len;
        else                            g_size = s_len;
    end

    for (genvar g = 0; g < NWALK; g++) begin : g_walk
        swz_walker #(.VL_W(VL_W)) u_walk (
            .clk   (clk),
            .rst   (rst),
            .init  (st_q == ST_LOAD),
            .adv   (fire),
            .mask  (w_mask[g]),
            .outer (w_outer[g]),
            .vl    (vl_q),
            .i_pos (w_i[g]),
            .j_pos (w_j[g]),
            .ex    (w_ex[g]),
            .last  (w_last[g])
        );
    end

    assign any_ex  = |w_ex;
    assign fire    = (st_q == ST_RUN) && !any_ex;
    assign last_mv = fire && (|w_last);
    assign cnt_hit = (cnt_q + 3'd1) == g_size;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cfg_q <= '0;
            vl_q  <= '0;
            cnt_q <= '0;
            grp_q <= 1'b0;
        end else begin
            grp_q <= fire && cfg_q.vf && (cnt_hit || last_mv);
            if (start) begin
                cfg_q <= '{swz: swz_imm, sub_m1: subvl_m1, pack: pack_en,
                           unpack: unpack_en, vf: vfirst, sat: sat_en,
                           sgn: sat_signed, ew: ew_sel};
                vl_q  <= vl_in;
                st_q  <= ST_LOAD;
                cnt_q <= '0;
                grp_q <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_LOAD: st_q <= ST_RUN;
                    ST_RUN: begin
                        if (!fire) begin
                            st_q <= ST_IDLE;
                        end else if (cfg_q.vf && cnt_hit && !last_mv) begin
                            st_q  <= ST_HOLD;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 3'd1;
                        end
                    end
                    ST_HOLD: if (step_req) st_q <= ST_RUN;
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        s_sel        = sel_of(cfg_q.swz, w_j[0]);
        mv_valid     = fire;
        mv_const     = !s_sel[2];
        mv_lane      = s_sel[1:0];
        mv_const_val = const_val(s_sel, cfg_q.sat, cfg_q.sgn, cfg_q.ew);
        if (cfg_q.pack)
            mv_src_idx = IDX_W'(s_sel[1:0]) * IDX_W'(vl_q) + IDX_W'(w_i[0]);
        else
            mv_src_idx = IDX_W'(w_i[0]) * IDX_W'(s_len) + IDX_W'(s_sel[1:0]);
        if (cfg_q.unpack)
            mv_dst_idx = IDX_W'(w_j[1]) * IDX_W'(vl_q) + IDX_W'(w_i[1]);
        else
            mv_dst_idx = IDX_W'(w_i[1]) * IDX_W'(d_len) + IDX_W'(w_j[1]);
        seq_done     = (st_q == ST_RUN) && any_ex;
        grp_done     = grp_q;
    end

    assign cfg_vf  = cfg_q.vf;
    assign cfg_sat = cfg_q.sat;

endmodule

// File: rtl/swz_seq_chk.sv
module swz_seq_chk #(
    parameter int VL_W = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            mv_valid,
    input logic            mv_const,
    input logic [63:0]     mv_const_val,
    input logic [VL_W+1:0] mv_dst_idx,
    input logic            seq_done,
    input logic            grp_done,
    input logic [VL_W-1:0] vl_q,
    input logic            cfg_vf,
    input logic            cfg_sat
);

    assert_start_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> (!mv_valid && !seq_done));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    assert_grp_only_vf_R11: assert property (@(posedge clk) disable iff (rst)
        grp_done |-> cfg_vf);

    assert_grp_follows_move_R10: assert property (@(posedge clk) disable iff (rst)
        grp_done |-> $past(mv_valid));

    assert_plain_const_R7: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && mv_const && !cfg_sat) |-> (mv_const_val <= 64'd1));

    assert_dst_range_R2: assert property (@(posedge clk) disable iff (rst)
        mv_valid |-> (mv_dst_idx < ({2'b00, vl_q} << 2)));

endmodule

bind swz_seq swz_seq_chk #(.VL_W(VL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .mv_valid     (mv_valid),
    .mv_const     (mv_const),
    .mv_const_val (mv_const_val),
    .mv_dst_idx   (mv_dst_idx),
    .seq_done     (seq_done),
    .grp_done     (grp_done),
    .vl_q         (vl_q),
    .cfg_vf       (cfg_vf),
    .cfg_sat      (cfg_sat)
);

// File: tb/sim_swz_seq.sv
`timescale 1ns/1ps
module sim_swz_seq;

    localparam int VL_W = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            step_req = 1'b0;
    logic [VL_W-1:0] vl_in = '0;
    logic [1:0]      subvl_m1 = '0;
    logic [11:0]     swz_imm = '0;
    logic            pack_en = 1'b0, unpack_en = 1'b0, vfirst = 1'b0;
    logic            sat_en = 1'b0, sat_signed = 1'b0;
    logic [1:0]      ew_sel = '0;
    logic            mv_valid, mv_const, grp_done, seq_done;
    logic [VL_W+1:0] mv_src_idx, mv_dst_idx;
    logic [1:0]      mv_lane;
    logic [63:0]     mv_const_val;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    swz_seq #(.VL_W(VL_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .step_req(step_req),
        .vl_in(vl_in), .subvl_m1(subvl_m1), .swz_imm(swz_imm),
        .pack_en(pack_en), .unpack_en(unpack_en), .vfirst(vfirst),
        .sat_en(sat_en), .sat_signed(sat_signed), .ew_sel(ew_sel),
        .mv_valid(mv_valid), .mv_const(mv_const), .mv_src_idx(mv_src_idx),
        .mv_lane(mv_lane), .mv_const_val(mv_const_val), .mv_dst_idx(mv_dst_idx),
        .grp_done(grp_done), .seq_done(seq_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] exp_const(input logic [2:0] sel, input bit st,
                                              input bit sg, input int ew);
        int w;
        w = 8 << ew;
        if (sel == 3'b010) return 64'd0;
        if (!st) return 64'd1;
        if (sg) return (64'd1 << (w - 1)) - 64'd1;
        if (w == 64) return {64{1'b1}};
        return (64'd1 << w) - 64'd1;
    endfunction

    task automatic run_case(input int vl, input int sm1, input logic [11:0] imm,
                            input bit pk, input bit up, input bit vf, input bit st,
                            input bit sg, input int ew, input int dly);
        bit          s_c [256];
        int          s_ix[256];
        int          s_ln[256];
        logic [63:0] s_cv[256];
        int          d_ix[256];
        int ns = 0, nd = 0, nexp, mp = 4, dlen, gsz;
        int k = 0, cyc = 0, ng = 0, lastg = 0, wl = 0, exp_k;
        bit pending = 0, prev_v = 0, finished = 0;

        for (int p = 3; p >= 0; p--) if (imm[3*p +: 3] == 3'b001) mp = p;
        dlen = (mp < 4) ? mp + 1 : 4;
        for (int a = 0; a < (pk ? 4 : vl); a++)
            for (int b = 0; b < (pk ? vl : 4); b++) begin
                int i = pk ? b : a;
                int j = pk ? a : b;
                logic [2:0] sel = imm[3*j +: 3];
                if (j <= sm1 && j < mp && sel != 3'b000) begin
                    s_c[ns]  = !sel[2];
                    s_ln[ns] = int'(sel[1:0]);
                    s_ix[ns] = pk ? s_ln[ns] * vl + i : i * (sm1 + 1) + s_ln[ns];
                    s_cv[ns] = exp_const(sel, st, sg, ew);
                    ns++;
                end
            end
        for (int a = 0; a < (up ? 4 : vl); a++)
            for (int b = 0; b < (up ? vl : 4); b++) begin
                int i = up ? b : a;
                int j = up ? a : b;
                if (j < dlen && imm[3*j +: 3] != 3'b000) begin
                    d_ix[nd] = up ? j * vl + i : i * dlen + j;
                    nd++;
                end
            end
        nexp = (ns < nd) ? ns : nd;
        gsz  = (pk && up) ? 1 : (pk ? dlen : sm1 + 1);

        @(negedge clk);
        vl_in = VL_W'(vl); subvl_m1 = 2'(sm1); swz_imm = imm;
        pack_en = pk; unpack_en = up; vfirst = vf;
        sat_en = st; sat_signed = sg; ew_sel = 2'(ew);
        start = 1'b1; step_req = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(!mv_valid && !seq_done, "R8 quiet after start", {mv_valid, seq_done}, 0);

        while (!finished && cyc < 3000) begin
            @(negedge clk);
            step_req = 1'b0;
            if (cyc == 0) begin
                if (nexp > 0) chk(mv_valid, "R8 first move timing", mv_valid, 1);
                else          chk(seq_done, "R9 empty sequence done", seq_done, 1);
            end
            if (pending) chk(!mv_valid, "R10 no move while held", mv_valid, 0);
            if (mv_valid) begin
                if (k < nexp) begin
                    chk(mv_const == s_c[k], "R1 constant flag", mv_const, s_c[k]);
                    if (!s_c[k]) begin
                        chk(mv_src_idx == s_ix[k], pk ? "R5 packed source" : "R3 source",
                            mv_src_idx, s_ix[k]);
                        chk(mv_lane == s_ln[k], "R3 lane", mv_lane, s_ln[k]);
                    end else begin
                        chk(mv_const_val == s_cv[k], "R7 constant value",
                            mv_const_val, s_cv[k]);
                    end
                    chk(mv_dst_idx == d_ix[k], up ? "R6 unpacked dest" : "R2 dest",
                        mv_dst_idx, d_ix[k]);
                end else begin
                    chk(0, "R4 extra move", k, nexp);
                end
                k++;
            end
            if (grp_done) begin
                chk(vf, "R11 group pulse outside vertical-first", grp_done, 0);
                exp_k = (lastg + gsz < nexp) ? lastg + gsz : nexp;
                chk(k == exp_k && prev_v, "R10 group boundary", k, exp_k);
                lastg = k;
                ng++;
                if (!seq_done) begin
                    pending = 1;
                    wl = dly;
                end
            end
            if (seq_done) begin
                chk(k == nexp, "R4 move count", k, nexp);
                if (!vf) chk(cyc == nexp, "R11 back-to-back moves", cyc, nexp);
                if (vf) begin
                    chk(grp_done == (nexp > 0), "R10 last group with done", grp_done, nexp > 0);
                    chk(ng == (nexp + gsz - 1) / gsz, "R10 group count", ng,
                        (nexp + gsz - 1) / gsz);
                end
                finished = 1;
            end
            if (pending) begin
                if (wl == 0) begin
                    step_req = 1'b1;
                    pending = 0;
                end else begin
                    wl--;
                end
            end else if (!vf) begin
                step_req = 1'($urandom % 2);
            end
            prev_v = mv_valid;
            cyc++;
        end
        if (!finished) chk(0, "R9 sequence never ended", 0, 1);
        @(negedge clk);
        step_req = 1'b0;
        chk(!seq_done && !mv_valid && !grp_done, "R9 single done pulse",
            {seq_done, mv_valid, grp_done}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R9 act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mv_valid && !seq_done && !grp_done, "R8 reset state",
            {mv_valid, seq_done, grp_done}, 0);

        // directed corners
        run_case(0, 3, 12'b100_101_110_111, 0, 0, 0, 0, 0, 0, 0);   // VL zero
        run_case(3, 3, 12'b000_000_000_000, 0, 0, 1, 0, 0, 0, 0);   // all skipped
        run_case(3, 2, 12'b001_111_100_110, 0, 0, 0, 0, 0, 0, 0);   // marker at W
        run_case(4, 3, 12'b010_001_100_101, 0, 1, 0, 0, 0, 0, 0);   // marker at Z
        run_case(2, 1, 12'b011_011_010_011, 0, 0, 0, 1, 1, 0, 0);   // sat s8
        run_case(2, 3, 12'b011_010_011_011, 0, 0, 0, 1, 0, 0, 0);   // sat u8
        run_case(2, 3, 12'b011_011_011_011, 0, 0, 0, 1, 1, 3, 0);   // sat s64
        run_case(2, 3, 12'b011_011_011_011, 0, 0, 0, 1, 0, 2, 0);   // sat u32
        run_case(5, 2, 12'b000_100_110_101, 1, 0, 1, 0, 0, 0, 2);   // pack vf
        run_case(4, 3, 12'b111_110_101_100, 1, 1, 1, 0, 0, 0, 1);   // both, vf
        run_case(5, 1, 12'b000_111_000_101, 0, 0, 1, 0, 0, 1, 0);   // short groups

        // restart while a long sequence is running
        @(negedge clk);
        vl_in = VL_W'(40); subvl_m1 = 2'd3; swz_imm = 12'b111_110_101_100;
        pack_en = 0; unpack_en = 0; vfirst = 0; sat_en = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        run_case(3, 1, 12'b000_000_100_101, 0, 1, 0, 0, 0, 0, 0);

        for (int n = 0; n < 90; n++) begin
            run_case($urandom % 10, $urandom % 4, 12'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     $urandom % 4, $urandom % 3);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule